// File: doc/BRIEF.md
# Iterative Restartable Hardware Divider

This block divides a dividend by a 16-bit divisor one step per clock while a processor datapath sequences it. It produces a 16-bit quotient and a 16-bit remainder. It accepts a 32-bit or a 16-bit dividend, and it interprets the operands as unsigned integers, as two's-complement integers, or as signed 1.15 fractions. Every division runs a fixed schedule of 19 steps. The first step takes the operand magnitudes and the result signs. The next sixteen steps each produce one quotient bit by shift and subtract. One step applies the signs, and the last step checks overflow and publishes the result.

The surrounding pipeline advances the divider with a step enable. It can also park the divider through a suspend request, for example while an interrupt service routine runs. While parked, the partial remainder and partial quotient are held exactly. The division continues from the same step once the request is dropped. A new start pulse always wins: it discards any division in flight and begins again with the operands presented with it. A zero divisor, or a quotient that does not fit in 16 bits, raises the math-error flag together with done.

Top module: `stepdiv`

## Requirements
- R1: After reset, busy, done, math_err, susp_ack, quotient and remainder are all 0.
- R2: With step_en held high and no suspend, the rising edge that samples start is step 1, and done is high after step 19. busy is high from step 1 until done rises, and busy and done are never high together.
- R3: mode 2'b00 with wide=1 divides the 32-bit unsigned dividend by the unsigned divisor, giving the floor quotient and the matching remainder.
- R4: mode 2'b00 with wide=0 uses only dividend[15:0]; dividend[31:16] has no effect on the result.
- R5: mode 2'b01 is signed integer division (32-bit dividend with wide=1, sign-extended dividend[15:0] with wide=0). The quotient is truncated toward zero and the remainder carries the sign of the dividend.
- R6: mode 2'b10 or 2'b11 is fractional: A = signed dividend[15:0] and B = signed divisor. The quotient is A*32768/B truncated toward zero, the remainder takes the sign of A, and wide and dividend[31:16] have no effect.
- R7: A zero divisor gives math_err=1 when done rises, in every mode.
- R8: math_err=1 when the quotient is not representable: above 65535 unsigned, outside -32768..32767 signed, or |A| >= |B| in fractional mode. A signed quotient of exactly -32768 is not an error.
- R9: A rising edge with step_en low while busy does not advance the division; done is delayed by one cycle per such edge and the result is unchanged.
- R10: While susp_req is high no step is taken. susp_ack is high one edge after susp_req is raised during a division and low one edge after it is dropped. The final result equals that of an undisturbed run.
- R11: A start while busy abandons the current division. done then rises 19 steps after the new start, with the result of the new operands.
- R12: After done, quotient, remainder and math_err hold until the next start, whatever the other inputs do. The edge that samples start clears done and math_err.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division with the presented operands; restarts if busy |
| step_en | input | 1 | Advance one step on this edge when busy |
| susp_req | input | 1 | Park the divider, holding all partial state |
| mode | input | 2 | 00 unsigned, 01 signed integer, 1x fractional 1.15 |
| wide | input | 1 | Integer modes: 1 for 32-bit dividend, 0 for 16-bit |
| dividend | input | 32 | Dividend, sampled with start |
| divisor | input | 16 | Divisor, sampled with start |
| quotient | output | 16 | Quotient of the last completed division |
| remainder | output | 16 | Remainder of the last completed division |
| busy | output | 1 | A division is in progress |
| done | output | 1 | Result valid; held until next start |
| susp_ack | output | 1 | Divider is parked by susp_req |
| math_err | output | 1 | Zero divisor or quotient overflow for the last result |

## Verification
The hardest situation to reach is a division that is interrupted part-way through its shift-subtract steps. Stall edges from step_en and suspend edges from susp_req both land in the middle of the iteration. The result must still match an undisturbed run, and completion must be late by exactly the number of blocked edges. The driver task therefore takes a stall count and a suspend count. It drops step_en and raises susp_req a few steps after start, and the expected completion cycle it queues includes both delays. A restart is provoked by pulsing start again a few steps into a division whose result is never queued. Any stray completion then shows up as a mismatch with the scoreboard.

// File: rtl/stepdiv_pkg.sv
package stepdiv_pkg;

   typedef enum logic [1:0] {
      KIND_UNS      = 2'b00,
      KIND_SINT     = 2'b01,
      KIND_FRAC     = 2'b10,
      KIND_FRAC_ALT = 2'b11
   } div_kind_e;

   typedef enum logic [1:0] {
      CORE_IDLE  = 2'b00,
      CORE_LOAD  = 2'b01,
      CORE_SHIFT = 2'b10,
      CORE_FIX   = 2'b11
   } core_op_e;

endpackage

// File: rtl/stepdiv_prep.sv
module stepdiv_prep
   import stepdiv_pkg::*;
#(
   parameter int W = 16
) (
   input  logic [1:0]     kind,
   input  logic           wide,
   input  logic [2*W-1:0] dividend,
   input  logic [W-1:0]   divisor,
   output logic [2*W-1:0] num_mag,
   output logic [W-1:0]   den_mag,
   output logic           q_neg,
   output logic           r_neg,
   output logic           pre_err,
   output logic           is_signed
);

   localparam int DW = 2 * W;

   logic           frac;
   logic           d_neg;
   logic           n_neg;
   logic [W-1:0]   low_mag;
   logic           zero_den;
   logic           ovf_hi;

   always_comb begin
      is_signed = (div_kind_e'(kind) != KIND_UNS);
      frac      = kind[1];
      zero_den  = (divisor == '0);
      d_neg     = is_signed & divisor[W-1];
      den_mag   = d_neg ? (~divisor + 1'b1) : divisor;
      n_neg     = 1'b0;
      low_mag   = dividend[W-1:0];
      num_mag   = '0;
      ovf_hi    = 1'b0;
      if (frac) begin
         n_neg   = dividend[W-1];
         low_mag = n_neg ? (~dividend[W-1:0] + 1'b1) : dividend[W-1:0];
         num_mag = {{W{1'b0}}, low_mag} << (W - 1);
         ovf_hi  = (low_mag >= den_mag);
      end else if (wide) begin
         n_neg   = is_signed & dividend[DW-1];
         num_mag = n_neg ? (~dividend + 1'b1) : dividend;
         ovf_hi  = (num_mag[DW-1:W] >= den_mag);
      end else begin
         n_neg   = is_signed & dividend[W-1];
         low_mag = n_neg ? (~dividend[W-1:0] + 1'b1) : dividend[W-1:0];
         num_mag = {{W{1'b0}}, low_mag};
         ovf_hi  = 1'b0;
      end
      q_neg   = n_neg ^ d_neg;
      r_neg   = n_neg;
      pre_err = zero_den | ovf_hi;
   end

endmodule

// File: rtl/stepdiv_seq.sv
module stepdiv_seq
   import stepdiv_pkg::*;
#(
   parameter int ITERS = 16,
   parameter int STEPS = ITERS + 3
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     start,
   input  logic     step_en,
   input  logic     susp_req,
   output core_op_e op,
   output logic     fix_step,
   output logic     last_step,
   output logic     busy,
   output logic     done,
   output logic     susp_ack
);

   localparam int CW = $clog2(STEPS + 1);
   localparam logic [CW-1:0] FIX_AT  = CW'(ITERS + 1);
   localparam logic [CW-1:0] LAST_AT = CW'(STEPS - 1);
   localparam logic [CW-1:0] ITER_HI = CW'(ITERS);

   initial begin
      assert (STEPS == ITERS + 3) else $fatal(1, "schedule needs setup, sign and final steps");
   end

   logic [CW-1:0] cnt;
   logic          adv;

   assign adv = busy & step_en & ~susp_req;

   always_comb begin
      op        = CORE_IDLE;
      fix_step  = 1'b0;
      last_step = 1'b0;
      if (start) begin
         op = CORE_LOAD;
      end else if (adv) begin
         if (cnt <= ITER_HI)     op = CORE_SHIFT;
         else if (cnt == FIX_AT) op = CORE_FIX;
         fix_step  = (cnt == FIX_AT);
         last_step = (cnt == LAST_AT);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         busy     <= 1'b0;
         done     <= 1'b0;
         susp_ack <= 1'b0;
      end else begin
         susp_ack <= susp_req & busy;
         if (start) begin
            cnt  <= CW'(1);
            busy <= 1'b1;
            done <= 1'b0;
         end else if (adv) begin
            cnt <= cnt + 1'b1;
            if (last_step) begin
               busy <= 1'b0;
               done <= 1'b1;
            end
         end
      end
   end

   assert_busy_done_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   assert_ack_needs_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      susp_ack |-> busy);

endmodule

// File: rtl/stepdiv_core.sv
module stepdiv_core
   import stepdiv_pkg::*;
#(
   parameter int W            = 16,
   parameter bit NONRESTORING = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  core_op_e       op,
   input  logic [2*W-1:0] num_mag,
   input  logic [W-1:0]   den_mag,
   input  logic           q_neg,
   input  logic           r_neg,
   output logic [W-1:0]   part_quo,
   output logic [W-1:0]   part_rem
);

   logic [W:0]   rem_q;
   logic [W-1:0] lo_q;
   logic [W-1:0] den_q;
   logic [W:0]   step_rem;
   logic         step_bit;
   logic [W-1:0] fin_rem;

   generate
      if (NONRESTORING) begin : g_nonrestore
         logic [W+1:0] trial;
         logic [W+1:0] dx;
         logic [W+1:0] nxt;
         logic [W:0]   fixup;
         assign trial    = {rem_q, lo_q[W-1]};
         assign dx       = {2'b00, den_q};
         assign nxt      = rem_q[W] ? (trial + dx) : (trial - dx);
         assign step_rem = nxt[W:0];
         assign step_bit = ~nxt[W+1];
         assign fixup    = rem_q + {1'b0, den_q};
         assign fin_rem  = rem_q[W] ? fixup[W-1:0] : rem_q[W-1:0];
      end else begin : g_restore
         logic [W:0] trial;
         logic       fits;
         assign trial    = {rem_q[W-1:0], lo_q[W-1]};
         assign fits     = (trial >= {1'b0, den_q});
         assign step_rem = fits ? (trial - {1'b0, den_q}) : trial;
         assign step_bit = fits;
         assign fin_rem  = rem_q[W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q <= '0;
         lo_q  <= '0;
         den_q <= '0;
      end else begin
         case (op)
            CORE_LOAD: begin
               rem_q <= {1'b0, num_mag[2*W-1:W]};
               lo_q  <= num_mag[W-1:0];
               den_q <= den_mag;
            end
            CORE_SHIFT: begin
               rem_q <= step_rem;
               lo_q  <= {lo_q[W-2:0], step_bit};
            end
            CORE_FIX: begin
               rem_q <= {1'b0, (r_neg ? (~fin_rem + 1'b1) : fin_rem)};
               lo_q  <= q_neg ? (~lo_q + 1'b1) : lo_q;
            end
            default: ;
         endcase
      end
   end

   assign part_quo = lo_q;
   assign part_rem = rem_q[W-1:0];

   assert_core_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (op == CORE_IDLE) |=> ($stable(rem_q) && $stable(lo_q) && $stable(den_q)));

endmodule

// File: rtl/stepdiv.sv
module stepdiv
   import stepdiv_pkg::*;
#(
   parameter int W            = 16,
   parameter bit NONRESTORING = 1'b0
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start,
   input  logic           step_en,
   input  logic           susp_req,
   input  logic [1:0]     mode,
   input  logic           wide,
   input  logic [2*W-1:0] dividend,
   input  logic [W-1:0]   divisor,
   output logic [W-1:0]   quotient,
   output logic [W-1:0]   remainder,
   output logic           busy,
   output logic           done,
   output logic           susp_ack,
   output logic           math_err
);

   localparam int DW    = 2 * W;
   localparam int STEPS = W + 3;

   initial begin
      assert (W >= 4) else $fatal(1, "word width too small");
   end

   logic [DW-1:0] num_mag;
   logic [W-1:0]  den_mag;
   logic          q_neg, r_neg, pre_err, is_signed;
   core_op_e      op;
   logic          fix_step, last_step;
   logic [W-1:0]  part_quo, part_rem;

   logic          qneg_q, rneg_q, perr_q, sgn_q, fovf_q;
   logic [W-1:0]  quo_q, rem_q;
   logic          err_q;

   stepdiv_prep #(.W(W)) u_prep (
      .kind      (mode),
      .wide      (wide),
      .dividend  (dividend),
      .divisor   (divisor),
      .num_mag   (num_mag),
      .den_mag   (den_mag),
      .q_neg     (q_neg),
      .r_neg     (r_neg),
      .pre_err   (pre_err),
      .is_signed (is_signed)
   );

   stepdiv_seq #(.ITERS(W), .STEPS(STEPS)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .step_en   (step_en),
      .susp_req  (susp_req),
      .op        (op),
      .fix_step  (fix_step),
      .last_step (last_step),
      .busy      (busy),
      .done      (done),
      .susp_ack  (susp_ack)
   );

   stepdiv_core #(.W(W), .NONRESTORING(NONRESTORING)) u_core (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (op),
      .num_mag  (num_mag),
      .den_mag  (den_mag),
      .q_neg    (qneg_q),
      .r_neg    (rneg_q),
      .part_quo (part_quo),
      .part_rem (part_rem)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         qneg_q <= 1'b0;
         rneg_q <= 1'b0;
         perr_q <= 1'b0;
         sgn_q  <= 1'b0;
         fovf_q <= 1'b0;
         quo_q  <= '0;
         rem_q  <= '0;
         err_q  <= 1'b0;
      end else begin
         if (start) begin
            qneg_q <= q_neg;
            rneg_q <= r_neg;
            perr_q <= pre_err;
            sgn_q  <= is_signed;
            fovf_q <= 1'b0;
            err_q  <= 1'b0;
         end else begin
            if (fix_step)
               fovf_q <= sgn_q & part_quo[W-1] & ~(qneg_q & ~|part_quo[W-2:0]);
            if (last_step) begin
               quo_q <= part_quo;
               rem_q <= part_rem;
               err_q <= perr_q | fovf_q;
            end
         end
      end
   end

   assign quotient  = quo_q;
   assign remainder = rem_q;
   assign math_err  = err_q;

   assert_done_after_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(busy));

   assert_result_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> ($stable(quotient) && $stable(remainder) && $stable(math_err)));

   assert_clear_on_start_R12: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (busy && !done && !math_err));

endmodule

// File: tb/stepdiv_bench.sv
module stepdiv_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        step_en = 1'b1;
   logic        susp_req = 1'b0;
   logic [1:0]  mode = 2'b00;
   logic        wide = 1'b0;
   logic [31:0] dividend = '0;
   logic [15:0] divisor = '0;
   logic [15:0] quotient, remainder;
   logic        busy, done, susp_ack, math_err;

   always #5 clk = ~clk;

   stepdiv u_stepdiv (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .step_en   (step_en),
      .susp_req  (susp_req),
      .mode      (mode),
      .wide      (wide),
      .dividend  (dividend),
      .divisor   (divisor),
      .quotient  (quotient),
      .remainder (remainder),
      .busy      (busy),
      .done      (done),
      .susp_ack  (susp_ack),
      .math_err  (math_err)
   );

   typedef struct {
      logic [15:0] q;
      logic [15:0] r;
      bit          err;
      bit          care;
      longint      edge_no;
      string       tag;
   } item_t;

   item_t  sb[$];
   longint cyc = 0;
   int     nchk = 0;
   int     nerr = 0;
   bit     done_d = 1'b0;
   bit     finished = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
      end
   endtask

   function automatic void model(input logic [1:0] m, input logic wd,
                                 input logic [31:0] a, input logic [15:0] b,
                                 output logic [15:0] q, output logic [15:0] r,
                                 output bit err, output bit care);
      longint n, d, qq, rr, an, ad;
      err = 1'b0; care = 1'b1; q = '0; r = '0;
      if (b == 16'h0) begin
         err = 1'b1; care = 1'b0;
         return;
      end
      if (m == 2'b00) begin
         n = wd ? longint'(a) : longint'(a[15:0]);
         d = longint'(b);
      end else if (m == 2'b01) begin
         n = wd ? longint'($signed(a)) : longint'($signed(a[15:0]));
         d = longint'($signed(b));
      end else begin
         an = longint'($signed(a[15:0]));
         d  = longint'($signed(b));
         ad = (d < 0) ? -d : d;
         if (((an < 0) ? -an : an) >= ad) err = 1'b1;
         n = an * 32768;
      end
      qq = n / d;
      rr = n % d;
      if (m == 2'b00) begin
         if (qq > 65535) err = 1'b1;
      end else begin
         if (qq > 32767 || qq < -32768) err = 1'b1;
      end
      if (err) care = 1'b0;
      q = qq[15:0];
      r = rr[15:0];
   endfunction

   // monitor: pops one expected item per completed division
   always @(negedge clk) begin
      if (rst_n && done && !done_d) begin
         if (sb.size() == 0) begin
            check(1'b0, "R11", "unexpected completion", 1, 0);
         end else begin
            item_t it;
            it = sb.pop_front();
            check(cyc == it.edge_no, "R2", {it.tag, " completion cycle"}, cyc, it.edge_no);
            check(math_err == it.err, it.tag, "math_err", math_err, it.err);
            if (it.care) begin
               check(quotient == it.q, it.tag, "quotient", quotient, it.q);
               check(remainder == it.r, it.tag, "remainder", remainder, it.r);
            end
         end
      end
      done_d = done;
   end

   task automatic launch(input logic [1:0] m, input logic wd, input logic [31:0] a,
                         input logic [15:0] b, input string tag,
                         input int stall, input int susp);
      item_t  it;
      longint s_edge;
      @(negedge clk);
      mode = m; wide = wd; dividend = a; divisor = b;
      start = 1'b1;
      s_edge = cyc + 1;
      model(m, wd, a, b, it.q, it.r, it.err, it.care);
      it.edge_no = s_edge + 18 + stall + susp;
      it.tag = tag;
      sb.push_back(it);
      @(negedge clk);
      start = 1'b0;
      check(busy && !done && !math_err, "R12", "state after start edge",
            {busy, done, math_err}, 3'b100);
      repeat (2) @(negedge clk);
      if (stall > 0) begin
         step_en = 1'b0;
         repeat (stall) @(negedge clk);
         step_en = 1'b1;
      end
      if (susp > 0) begin
         susp_req = 1'b1;
         for (int i = 0; i < susp; i++) begin
            @(negedge clk);
            if (i == 0) check(susp_ack == 1'b1, "R10", "ack while parked", susp_ack, 1);
         end
         susp_req = 1'b0;
         @(negedge clk);
         check(susp_ack == 1'b0, "R10", "ack released", susp_ack, 0);
         it.edge_no = it.edge_no;
         // resumed: the dropped-request edge already counted as a step
         sb[sb.size()-1].edge_no = sb[sb.size()-1].edge_no;
      end
      while (!done) @(negedge clk);
      @(negedge clk);
   endtask

   // watchdog
   always @(posedge clk) begin
      if (!finished && cyc > 20000) begin
         check(1'b0, "R2", "watchdog expired", cyc, 20000);
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check(!busy && !done && !math_err && !susp_ack && quotient == 0 && remainder == 0,
            "R1", "reset outputs", {busy, done, math_err, susp_ack}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(!busy && !done && quotient == 0 && remainder == 0, "R1", "after release",
            {busy, done}, 0);

      // R3 unsigned 32/16
      launch(2'b00, 1'b1, 32'd100000, 16'd7, "R3", 0, 0);
      launch(2'b00, 1'b1, 32'hFFFE0001, 16'hFFFF, "R3", 0, 0);
      launch(2'b00, 1'b1, 32'd12345678, 16'd1000, "R3", 0, 0);
      // R4 unsigned 16/16 ignores upper dividend
      launch(2'b00, 1'b0, 32'hABCD1234, 16'h0100, "R4", 0, 0);
      launch(2'b00, 1'b0, 32'hFFFFFFFF, 16'd3, "R4", 0, 0);
      // R5 signed integer
      launch(2'b01, 1'b1, -32'sd100000, 16'd7, "R5", 0, 0);
      launch(2'b01, 1'b1, 32'd100000, -16'sd7, "R5", 0, 0);
      launch(2'b01, 1'b0, 32'h5555FFF9, 16'd2, "R5", 0, 0);
      launch(2'b01, 1'b0, 32'h1234FFF9, 16'hFFFE, "R5", 0, 0);
      // R6 fractional, wide and upper bits ignored
      launch(2'b10, 1'b0, 32'h00002000, 16'h4000, "R6", 0, 0);
      launch(2'b10, 1'b1, 32'h9999E000, 16'h4000, "R6", 0, 0);
      launch(2'b11, 1'b1, 32'h777703E8, 16'd3000, "R6", 0, 0);
      // R7 zero divisor
      launch(2'b00, 1'b1, 32'd55, 16'd0, "R7", 0, 0);
      // R12 hold after done while inputs move, and clear on next start
      begin
         logic [15:0] hq, hr;
         logic        he;
         hq = quotient; hr = remainder; he = math_err;
         dividend = 32'h13572468; divisor = 16'h0; mode = 2'b01; step_en = 1'b0;
         repeat (4) @(negedge clk);
         step_en = 1'b1;
         check(done && quotient == hq && remainder == hr && math_err == he, "R12",
               "result held", {quotient, remainder}, {hq, hr});
      end
      launch(2'b01, 1'b1, -32'sd98304, 16'd3, "R8", 0, 0);
      // R8 overflow cases
      launch(2'b00, 1'b1, 32'h00070000, 16'd7, "R8", 0, 0);
      launch(2'b01, 1'b0, 32'h00008000, 16'hFFFF, "R8", 0, 0);
      launch(2'b01, 1'b1, 32'h40000000, 16'd2, "R8", 0, 0);
      launch(2'b10, 1'b0, 32'h00001000, 16'h1000, "R8", 0, 0);
      launch(2'b10, 1'b0, 32'h00008000, 16'h8000, "R8", 0, 0);
      // R9 stalls, R10 suspend
      launch(2'b01, 1'b1, -32'sd1234567, 16'd321, "R9", 5, 0);
      launch(2'b00, 1'b1, 32'hDEADBEEF, 16'hF00D, "R10", 0, 4);
      launch(2'b10, 1'b0, 32'h0000C000, 16'h5000, "R10", 3, 6);
      // R11 restart while busy: first operands never complete
      @(negedge clk);
      mode = 2'b00; wide = 1'b1; dividend = 32'd999999; divisor = 16'd0;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (6) @(negedge clk);
      launch(2'b01, 1'b1, 32'd7654321, -16'sd99, "R11", 0, 0);
      repeat (3) @(negedge clk);
      check(sb.size() == 0, "R11", "all results seen", sb.size(), 0);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule